// File: doc/BRIEF.md
# Debug-Unit Register Access Sequencer

This block turns single register requests from a host into the ordered list of shift commands that reach the registers of an on-chip debug unit. That debug unit sits on scan chain 2 behind a JTAG test access port. The block does not toggle the TAP pins itself. It hands one command at a time to a separate bit-level shift engine. Each command names the path (instruction or data register), a bit count, the bits to shift and the way the shift ends. The block then waits for that command to finish.

Before any frame is shifted, the block makes sure the debug unit's chain is connected. It shifts the chain-select instruction, then the chain number, then the internal-test instruction. It keeps the number of the chain it last selected. While that number is valid and equal to the target chain, it skips the first two steps and reissues only the test instruction.

A write is one 38-bit frame built from three sub-shifts: data, then address, then a read/write bit. A read needs two data passes. The first posts the address with a read/write bit of 0. The second shifts out the 32-bit register value, which the block returns together with done.

Top module: `dbg_reg_seq`

## Requirements
- R1: While rstN is low and in the first cycle after it rises, engReq and done are 0 and rdData is 0. The cached chain number starts out invalid.
- R2: When the cache is invalid, an access begins with three commands: an instruction shift of 4 bits with value 0x2 (chain select), then a data shift of 4 bits with value 2 (chain number), each with engExit=1 and engIdle=0, then an instruction shift of 4 bits with value 0xC (internal test) with engExit=1 and engIdle=1. A chain-select step must never carry engIdle=1.
- R3: When the cached chain equals 2, an access begins with only the 4-bit internal-test instruction shift (value 0xC, engExit=1, engIdle=1).
- R4: A write then issues three data shifts: 32 bits of write data (engExit=0, engIdle=0), 5 bits of address (engExit=0, engIdle=0), and 1 bit of value 1 (engExit=1, engIdle=1).
- R5: A read then issues three data shifts: 5 bits of address (engExit=0, engIdle=0), 1 bit of value 0 (engExit=1, engIdle=1), and 32 bits of value 0 (engExit=1, engIdle=1). The engCapture of that last shift becomes rdData.
- R6: done is a one-cycle pulse in the cycle after the engDone of the final command. rdData changes only in a cycle where done is high. It keeps its value until the next read completes, and writes leave it unchanged.
- R7: A tapReset pulse invalidates the cached chain, so the next access performs the full selection of R2.
- R8: reqValid is sampled only while the block is idle. A request raised while an access is in progress issues no command and does not alter the commands of the current access.
- R9: Bits to shift sit right-aligned in engData, and bit 0 is shifted first. engReq stays high with every command field stable until engDone, falls in the next cycle, and stays low for at least one cycle before the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tapReset | input | 1 | Pulse: the TAP was reset, invalidate cached chain |
| reqValid | input | 1 | Host request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Debug-unit register address |
| reqWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| engReq | output | 1 | Command valid to shift engine |
| engIsIr | output | 1 | 1 = instruction path, 0 = data path |
| engLen | output | LEN_W | Number of bits to shift |
| engData | output | DATA_W | Bits to shift, LSB first |
| engExit | output | 1 | Raise TMS on the last bit to leave the shift state |
| engIdle | output | 1 | After update go to Run-Test/Idle; 0 = go straight to Select-DR |
| engDone | input | 1 | Engine finished the command |
| engCapture | input | DATA_W | Bits captured during the command, first bit at bit 0 |

## Verification
The bench builds the block with its default parameters: 32 data bits, 5 address bits, 4-bit instruction and chain-select fields, target chain 2, and instruction codes 0x2 and 0xC. Full-width frames are therefore in play. Both ends of the address range (0 and 31), an all-ones write word and a zero read value can all be reached. A behavioural engine model checks every issued command against a queue that the access tasks fill. This covers the long and short preambles, cache invalidation after a TAP reset, and a request injected mid-access.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  // Shift steps of an access, in the order they can be issued
  typedef enum logic [2:0] {
    STEP_SEL_IR    = 3'd0,
    STEP_SEL_CHAIN = 3'd1,
    STEP_TEST_IR   = 3'd2,
    STEP_WDATA     = 3'd3,
    STEP_ADDR      = 3'd4,
    STEP_RWBIT     = 3'd5,
    STEP_RDATA     = 3'd6
  } seqStep_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     loadCmd;
    logic     retire;
    logic     setCache;
    logic     captureRd;
    seqStep_t step;
  } seqStrobe_t;

endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       engDone,
  input  logic       cacheHit,
  input  logic       opWrite,
  output seqStrobe_t strobes,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} ctlState_t;

  ctlState_t state, stateNext;
  seqStep_t  step, stepNext;
  logic      lastStep;

  function automatic seqStep_t followStep(seqStep_t s, logic wr);
    case (s)
      STEP_SEL_IR:    return STEP_SEL_CHAIN;
      STEP_SEL_CHAIN: return STEP_TEST_IR;
      STEP_TEST_IR:   return wr ? STEP_WDATA : STEP_ADDR;
      STEP_WDATA:     return STEP_ADDR;
      STEP_ADDR:      return STEP_RWBIT;
      STEP_RWBIT:     return STEP_RDATA;
      default:        return STEP_RDATA;
    endcase
  endfunction

  always_comb lastStep = (step == STEP_RDATA) || ((step == STEP_RWBIT) && opWrite);

  always_comb begin
    strobes   = '0;
    strobes.step = step;
    stateNext = state;
    stepNext  = step;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobes.latchReq = 1'b1;
          stepNext  = cacheHit ? STEP_TEST_IR : STEP_SEL_IR;
          stateNext = S_ISSUE;
        end
      end
      S_ISSUE: begin
        strobes.loadCmd = 1'b1;
        stateNext = S_WAIT;
      end
      default: begin
        if (engDone) begin
          strobes.retire    = 1'b1;
          strobes.setCache  = (step == STEP_SEL_CHAIN);
          strobes.captureRd = (step == STEP_RDATA);
          if (lastStep) begin
            stateNext = S_IDLE;
          end else begin
            stepNext  = followStep(step, opWrite);
            stateNext = S_ISSUE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= STEP_SEL_IR;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      step  <= stepNext;
      done  <= (state == S_WAIT) && engDone && lastStep;
    end
  end

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: completion follows an engine completion
  a_r6_done_after_eng: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(engDone));

  // R8: no request is taken while an access runs
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) && !engDone |=> !strobes.latchReq);

endmodule

// File: rtl/dbg_seq_dp.sv
module dbg_seq_dp
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int IR_W     = 4,
  parameter int CHAIN_ID = 2,
  parameter logic [IR_W-1:0] CODE_SCAN   = 4'h2,
  parameter logic [IR_W-1:0] CODE_INTEST = 4'hC,
  localparam int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapReset,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  seqStrobe_t        strobes,
  input  logic              engDone,
  input  logic [DATA_W-1:0] engCapture,
  output logic              opWrite,
  output logic              cacheHit,
  output logic              engReq,
  output logic              engIsIr,
  output logic [LEN_W-1:0]  engLen,
  output logic [DATA_W-1:0] engData,
  output logic              engExit,
  output logic              engIdle,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [IR_W-1:0] CHAIN_CODE = IR_W'(CHAIN_ID);

  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opWdata;
  logic              cacheValid;
  logic [IR_W-1:0]   cacheChain;

  // Next command fields for the current step
  logic              cmdIsIr, cmdExit, cmdIdle;
  logic [LEN_W-1:0]  cmdLen;
  logic [DATA_W-1:0] cmdData;

  generate
    if (DATA_W < IR_W || DATA_W < ADDR_W) begin : g_bad_width
      initial $display("dbg_seq_dp: DATA_W narrower than a field");
    end
  endgenerate

  always_comb cacheHit = cacheValid && (cacheChain == CHAIN_CODE);

  always_comb begin
    cmdIsIr = 1'b0;
    cmdExit = 1'b1;
    cmdIdle = 1'b1;
    cmdLen  = LEN_W'(IR_W);
    cmdData = '0;
    case (strobes.step)
      STEP_SEL_IR: begin
        cmdIsIr = 1'b1;
        cmdIdle = 1'b0;
        cmdData = DATA_W'(CODE_SCAN);
      end
      STEP_SEL_CHAIN: begin
        cmdIdle = 1'b0;
        cmdData = DATA_W'(CHAIN_CODE);
      end
      STEP_TEST_IR: begin
        cmdIsIr = 1'b1;
        cmdData = DATA_W'(CODE_INTEST);
      end
      STEP_WDATA: begin
        cmdExit = 1'b0;
        cmdIdle = 1'b0;
        cmdLen  = LEN_W'(DATA_W);
        cmdData = opWdata;
      end
      STEP_ADDR: begin
        cmdExit = 1'b0;
        cmdIdle = 1'b0;
        cmdLen  = LEN_W'(ADDR_W);
        cmdData = DATA_W'(opAddr);
      end
      STEP_RWBIT: begin
        cmdLen  = LEN_W'(1);
        cmdData = DATA_W'(opWrite);
      end
      default: begin
        cmdLen  = LEN_W'(DATA_W);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opWrite <= 1'b0;
      opAddr  <= '0;
      opWdata <= '0;
    end else if (strobes.latchReq) begin
      opWrite <= reqWrite;
      opAddr  <= reqAddr;
      opWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engReq  <= 1'b0;
      engIsIr <= 1'b0;
      engLen  <= '0;
      engData <= '0;
      engExit <= 1'b0;
      engIdle <= 1'b0;
    end else if (strobes.loadCmd) begin
      engReq  <= 1'b1;
      engIsIr <= cmdIsIr;
      engLen  <= cmdLen;
      engData <= cmdData;
      engExit <= cmdExit;
      engIdle <= cmdIdle;
    end else if (strobes.retire) begin
      engReq  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || tapReset) begin
      cacheValid <= 1'b0;
      cacheChain <= '0;
    end else if (strobes.setCache) begin
      cacheValid <= 1'b1;
      cacheChain <= CHAIN_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.captureRd) begin
      rdData <= engCapture;
    end
  end

  // R9: command held stable until the engine finishes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    engReq && !engDone |=> engReq && $stable(engData) && $stable(engLen)
                           && $stable(engIsIr) && $stable(engExit) && $stable(engIdle));

  // R9: command withdrawn after completion
  a_r9_drop: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engDone |=> !engReq);

  // R2: a chain-select instruction never routes through Run-Test/Idle
  a_r2_select_no_idle: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engIsIr && (engData[IR_W-1:0] == CODE_SCAN) |-> engExit && !engIdle);

  // R7: TAP reset drops the cached chain
  a_r7_invalidate: assert property (@(posedge clk) disable iff (!rstN)
    tapReset |=> !cacheHit);

endmodule

// File: rtl/dbg_reg_seq.sv
module dbg_reg_seq
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int IR_W     = 4,
  parameter int CHAIN_ID = 2,
  parameter logic [IR_W-1:0] CODE_SCAN   = 4'h2,
  parameter logic [IR_W-1:0] CODE_INTEST = 4'hC,
  localparam int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tapReset,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              engReq,
  output logic              engIsIr,
  output logic [LEN_W-1:0]  engLen,
  output logic [DATA_W-1:0] engData,
  output logic              engExit,
  output logic              engIdle,
  input  logic              engDone,
  input  logic [DATA_W-1:0] engCapture
);

  seqStrobe_t strobes;
  logic       cacheHit;
  logic       opWrite;

  dbg_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .engDone  (engDone),
    .cacheHit (cacheHit),
    .opWrite  (opWrite),
    .strobes  (strobes),
    .done     (done)
  );

  dbg_seq_dp #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .IR_W        (IR_W),
    .CHAIN_ID    (CHAIN_ID),
    .CODE_SCAN   (CODE_SCAN),
    .CODE_INTEST (CODE_INTEST)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tapReset   (tapReset),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .strobes    (strobes),
    .engDone    (engDone),
    .engCapture (engCapture),
    .opWrite    (opWrite),
    .cacheHit   (cacheHit),
    .engReq     (engReq),
    .engIsIr    (engIsIr),
    .engLen     (engLen),
    .engData    (engData),
    .engExit    (engExit),
    .engIdle    (engIdle),
    .rdData     (rdData)
  );

endmodule

// File: tb/test_dbg_reg_seq.sv
module test_dbg_reg_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tapReset = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [4:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rdData;
  logic        done;
  logic        engReq, engIsIr, engExit, engIdle;
  logic [5:0]  engLen;
  logic [31:0] engData;
  logic        engDone = 1'b0;
  logic [31:0] engCapture = '0;

  int checks = 0;
  int errors = 0;
  int extraCmds = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          isIr;
    int          len;
    logic [31:0] data;
    bit          ex;
    bit          idle;
    logic [31:0] cap;
    string       req;
  } cmdItem_t;

  cmdItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_reg_seq i_dbg_reg_seq (
    .clk(clk), .rstN(rstN), .tapReset(tapReset),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .done(done),
    .engReq(engReq), .engIsIr(engIsIr), .engLen(engLen), .engData(engData),
    .engExit(engExit), .engIdle(engIdle), .engDone(engDone), .engCapture(engCapture)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic cmdItem_t mk(bit ir, int len, logic [31:0] d, bit ex, bit idle,
                                  logic [31:0] cap, string req);
    cmdItem_t c;
    c.isIr = ir; c.len = len; c.data = d; c.ex = ex; c.idle = idle; c.cap = cap; c.req = req;
    return c;
  endfunction

  // Engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && engReq) begin
        cmdItem_t e;
        logic [31:0] cap;
        cap = '0;
        if (expQ.size() == 0) begin
          extraCmds++;
          check(1'b0, "R8 unexpected command", {32'd0, engData}, 64'd0);
        end else begin
          e = expQ.pop_front();
          cap = e.cap;
          check(engIsIr == e.isIr && int'(engLen) == e.len && engData == e.data &&
                engExit == e.ex && engIdle == e.idle, e.req,
                {engIsIr, engExit, engIdle, 7'd0, 22'(engLen), engData},
                {e.isIr, e.ex, e.idle, 7'd0, 22'(e.len), e.data});
        end
        repeat (3) @(negedge clk);
        engDone = 1'b1;
        engCapture = cap;
        @(negedge clk);
        engDone = 1'b0;
        engCapture = '0;
      end
    end
  end

  // Driver: queue the expected commands, then issue the request and wait for done
  task automatic doAccess(input bit wr, input logic [4:0] a, input logic [31:0] wd,
                          input bit hit, input logic [31:0] cap);
    int t;
    if (!hit) begin
      expQ.push_back(mk(1, 4, 32'h2, 1, 0, 0, "R2 chain-select instruction"));
      expQ.push_back(mk(0, 4, 32'h2, 1, 0, 0, "R2 chain number"));
      expQ.push_back(mk(1, 4, 32'hC, 1, 1, 0, "R2 test instruction"));
    end else begin
      expQ.push_back(mk(1, 4, 32'hC, 1, 1, 0, "R3 test instruction only"));
    end
    if (wr) begin
      expQ.push_back(mk(0, 32, wd, 0, 0, 0, "R4 write data"));
      expQ.push_back(mk(0, 5, 32'(a), 0, 0, 0, "R4 address"));
      expQ.push_back(mk(0, 1, 32'h1, 1, 1, 0, "R4 write bit"));
    end else begin
      expQ.push_back(mk(0, 5, 32'(a), 0, 0, 0, "R5 address"));
      expQ.push_back(mk(0, 1, 32'h0, 1, 1, 0, "R5 read bit"));
      expQ.push_back(mk(0, 32, 32'h0, 1, 1, cap, "R5 value shift"));
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R6 done seen", {63'd0, done}, 64'd1);
    check(expQ.size() == 0, "R6 all commands before done", 64'(expQ.size()), 64'd0);
    if (!wr) check(rdData == cap, "R5 read data", {32'd0, rdData}, {32'd0, cap});
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(engReq == 0 && done == 0 && rdData == 0, "R1 in reset",
          {engReq, done, 30'd0, rdData}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(engReq == 0 && done == 0 && rdData == 0, "R1 after reset",
          {engReq, done, 30'd0, rdData}, 64'd0);

    // R2 + R4: first access after reset takes the full preamble
    doAccess(1, 5'h01, 32'hDEADBEEF, 0, 0);
    // R3 + R4: cached chain, boundary address and all-ones data
    doAccess(1, 5'h1F, 32'hFFFFFFFF, 1, 0);
    // R3 + R5: read at address 0
    doAccess(0, 5'h00, 32'h0, 1, 32'h12345678);

    // R6: read data holds while idle and across a write
    repeat (8) @(negedge clk);
    check(rdData == 32'h12345678, "R6 hold while idle", {32'd0, rdData}, 64'h12345678);
    doAccess(1, 5'h03, 32'h0F0F0F0F, 1, 0);
    check(rdData == 32'h12345678, "R6 write leaves read data", {32'd0, rdData}, 64'h12345678);

    // R7: TAP reset forces the full selection again
    @(negedge clk);
    tapReset = 1'b1;
    @(negedge clk);
    tapReset = 1'b0;
    doAccess(0, 5'h1F, 32'h0, 0, 32'hA5A5C3C3);

    // R8: request raised mid-access is dropped
    fork
      doAccess(0, 5'h0A, 32'h0, 1, 32'h00000000);
      begin
        repeat (6) @(negedge clk);
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 5'h15; reqWdata = 32'h55555555;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join
    repeat (30) @(negedge clk);
    check(extraCmds == 0, "R8 no extra commands", 64'(extraCmds), 64'd0);
    held = rdData;
    check(held == 32'h0, "R5 zero read value", {32'd0, held}, 64'd0);

    // R9: engine idle between accesses
    check(engReq == 1'b0, "R9 request low when idle", {63'd0, engReq}, 64'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule